// File: doc/BRIEF.md
# Diagnostic Access Unlock Sequencer

This block protects a host-visible diagnostic control register. The register ignores all writes until software has written a fixed four-value key, in order, to a separate sequence register. Once the key is accepted the unit is open. Software can then set the diagnostic control bits, clear a latched signature-fault flag, or request an adapter reset. A reset request produces a one-cycle pulse on `adapter_rst`, sets a sticky reset-history bit, and locks the unit again.

The key matcher is a six-state machine:

- **ST_LOCKED**: waiting for the first key.
- **ST_KEY1, ST_KEY2, ST_KEY3**: that many keys have been matched.
- **ST_OPEN**: diagnostic writes are accepted.
- **ST_FIRE**: the single reset-pulse cycle.

The transitions are:

- **advance**: the expected key arrives on the sequence register, so the machine moves one state forward. From ST_KEY3 this leads into ST_OPEN.
- **restart**: a non-matching sequence value equal to the first key goes to ST_KEY1.
- **miss**: any other non-matching sequence value goes to ST_LOCKED.
- **abandon**: a diagnostic write while the machine is locked or partly matched goes to ST_LOCKED.
- **configure**: a diagnostic write in ST_OPEN with the reset bit clear stays in ST_OPEN.
- **fire**: a diagnostic write in ST_OPEN with the reset bit set goes to ST_FIRE.
- **expire**: ST_FIRE always leaves after one cycle. It goes to ST_KEY1 if the first key arrives in that cycle, and to ST_LOCKED otherwise.
- **relock**: any sequence write in ST_OPEN leaves it. The first key goes to ST_KEY1, and any other value goes to ST_LOCKED.

Writes to other offsets and all reads leave the state unchanged.

Top module: `diag_unlock_seq`

## Requirements
- R1: After reset the state is ST_LOCKED, `adapter_rst` is 0 and the diagnostic register reads 0x000.
- R2: Writing 0x04, 0x02, 0x07, 0x0D, in that order, to offset 0x04 (full data word compared) opens the unit. Bit 7 of the diagnostic register then reads 1.
- R3: A wrong value at any key step returns the matcher to the first-key state. A wrong value equal to 0x04 counts as the first key.
- R4: While the unit is not open, a write to offset 0x08 leaves every diagnostic bit unchanged and abandons any partial key match.
- R5: Writes to offsets other than 0x04 and 0x08, and all reads, do not disturb the matcher.
- R6: While open, a write to offset 0x08 loads bit 0 (memory enable), bit 1 (processor disable), bit 4 (read/write enable) and bit 9 (boot prevent) from the data. If data bit 2 is 0 the unit stays open.
- R7: While open, writing data bit 2 drives `adapter_rst` high for exactly the one cycle after the write. The same write sets bit 5 (reset history) and locks the unit, so bit 7 reads 0.
- R8: An open write with data bit 10 set clears bit 6 (signature fault). Bits 2 and 10 always read 0.
- R9: `sig_fault_set` sets bit 6 whatever the lock state, and it takes priority over a clear in the same cycle.
- R10: Any write to offset 0x04 while the unit is open locks it. A value of 0x04 starts a new key match.
- R11: `rd_data` shows the diagnostic register in the same cycle when `rd_en` is 1 and `rd_addr` is 0x08, and reads 0 otherwise. Bits 3, 8 and 11 upward read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read offset |
| rd_data | output | 32 | Read data (diagnostic register or zero) |
| sig_fault_set | input | 1 | Event that latches the signature-fault bit |
| adapter_rst | output | 1 | One-cycle adapter reset request |

## Verification
The bench targets the restart corner, where a stray 0x04 in the middle of the key must count as a new first key. A matcher that simply drops to ST_LOCKED would then never open, and one that ignores the mismatch would open on a wrong sequence. It also checks that a diagnostic write between keys abandons the match; a design that missed this would open anyway and let later bits through. The reset write is checked for a pulse exactly one cycle wide, for the history bit, and for an immediate relock; a design that stays open would accept a second reset with no new key. Finally, the bench drives a fault event and a clear in the same cycle, where the wrong priority would lose the fault.

// File: rtl/diag_unlock_pkg.sv
`timescale 1ns/1ps
package diag_unlock_pkg;

    typedef enum logic [2:0] {
        ST_LOCKED,
        ST_KEY1,
        ST_KEY2,
        ST_KEY3,
        ST_OPEN,
        ST_FIRE
    } unlock_state_e;

    localparam int KEY_COUNT = 4;

    // diagnostic register bit positions (decoded by software)
    localparam int B_MEM_EN   = 0;
    localparam int B_CPU_OFF  = 1;
    localparam int B_RESET    = 2;
    localparam int B_RW_EN    = 4;
    localparam int B_HISTORY  = 5;
    localparam int B_SIG_BAD  = 6;
    localparam int B_OPEN     = 7;
    localparam int B_NO_BOOT  = 9;
    localparam int B_CLR_SIG  = 10;
    localparam int DIAG_BITS  = 11;

endpackage

// File: rtl/diag_addr_dec.sv
`timescale 1ns/1ps
module diag_addr_dec #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SEQ_OFS  = 8'h04,
    parameter logic [ADDR_W-1:0] DIAG_OFS = 8'h08
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              seq_wr,
    output logic              diag_wr,
    output logic              diag_rd
);

    always_comb begin
        seq_wr  = wr_en && (wr_addr == SEQ_OFS);
        diag_wr = wr_en && (wr_addr == DIAG_OFS);
        diag_rd = rd_en && (rd_addr == DIAG_OFS);
    end

endmodule

// File: rtl/diag_key_fsm.sv
`timescale 1ns/1ps
module diag_key_fsm
    import diag_unlock_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY0   = 32'h04,
    parameter logic [DATA_W-1:0] KEY1   = 32'h02,
    parameter logic [DATA_W-1:0] KEY2   = 32'h07,
    parameter logic [DATA_W-1:0] KEY3   = 32'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_wr,
    input  logic              diag_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              unlocked,
    output logic              accept_wr,
    output logic              fire
);

    localparam logic [DATA_W-1:0] KEYS [KEY_COUNT] = '{KEY0, KEY1, KEY2, KEY3};

    unlock_state_e state_q, state_d;
    logic [KEY_COUNT-1:0] key_hit;

    generate
        for (genvar g = 0; g < KEY_COUNT; g++) begin : g_key_cmp
            assign key_hit[g] = (wr_data == KEYS[g]);
        end
    endgenerate

    // sequence value that does not advance: restart or miss
    function automatic unlock_state_e fallback(input logic first_hit);
        return first_hit ? ST_KEY1 : ST_LOCKED;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (seq_wr)       state_d = fallback(key_hit[0]);
            end
            ST_KEY1: begin
                if (seq_wr)       state_d = key_hit[1] ? ST_KEY2 : fallback(key_hit[0]);
                else if (diag_wr) state_d = ST_LOCKED;
            end
            ST_KEY2: begin
                if (seq_wr)       state_d = key_hit[2] ? ST_KEY3 : fallback(key_hit[0]);
                else if (diag_wr) state_d = ST_LOCKED;
            end
            ST_KEY3: begin
                if (seq_wr)       state_d = key_hit[3] ? ST_OPEN : fallback(key_hit[0]);
                else if (diag_wr) state_d = ST_LOCKED;
            end
            ST_OPEN: begin
                if (seq_wr)       state_d = fallback(key_hit[0]);
                else if (diag_wr) state_d = wr_data[B_RESET] ? ST_FIRE : ST_OPEN;
            end
            ST_FIRE: begin
                state_d = (seq_wr) ? fallback(key_hit[0]) : ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unlocked  = (state_q == ST_OPEN);
        fire      = (state_q == ST_FIRE);
        accept_wr = diag_wr && (state_q == ST_OPEN);
    end

endmodule

// File: rtl/diag_ctl_bits.sv
`timescale 1ns/1ps
module diag_ctl_bits
    import diag_unlock_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_wr,
    input  logic              d_mem_en,
    input  logic              d_cpu_off,
    input  logic              d_reset,
    input  logic              d_rw_en,
    input  logic              d_no_boot,
    input  logic              d_clr_sig,
    input  logic              sig_fault_set,
    input  logic              unlocked,
    output logic [DATA_W-1:0] diag_val
);

    logic mem_en_q, cpu_off_q, rw_en_q, no_boot_q, history_q, sig_bad_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_en_q  <= 1'b0;
            cpu_off_q <= 1'b0;
            rw_en_q   <= 1'b0;
            no_boot_q <= 1'b0;
        end else if (accept_wr) begin
            mem_en_q  <= d_mem_en;
            cpu_off_q <= d_cpu_off;
            rw_en_q   <= d_rw_en;
            no_boot_q <= d_no_boot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                    history_q <= 1'b0;
        else if (accept_wr && d_reset) history_q <= 1'b1;
    end

    // fault event wins over a host clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                      sig_bad_q <= 1'b0;
        else if (sig_fault_set)          sig_bad_q <= 1'b1;
        else if (accept_wr && d_clr_sig) sig_bad_q <= 1'b0;
    end

    always_comb begin
        diag_val            = '0;
        diag_val[B_MEM_EN]  = mem_en_q;
        diag_val[B_CPU_OFF] = cpu_off_q;
        diag_val[B_RW_EN]   = rw_en_q;
        diag_val[B_HISTORY] = history_q;
        diag_val[B_SIG_BAD] = sig_bad_q;
        diag_val[B_OPEN]    = unlocked;
        diag_val[B_NO_BOOT] = no_boot_q;
    end

endmodule

// File: rtl/diag_unlock_seq.sv
`timescale 1ns/1ps
module diag_unlock_seq
    import diag_unlock_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SEQ_OFS  = 8'h04,
    parameter logic [ADDR_W-1:0] DIAG_OFS = 8'h08,
    parameter logic [DATA_W-1:0] KEY0     = 32'h04,
    parameter logic [DATA_W-1:0] KEY1     = 32'h02,
    parameter logic [DATA_W-1:0] KEY2     = 32'h07,
    parameter logic [DATA_W-1:0] KEY3     = 32'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sig_fault_set,
    output logic              adapter_rst
);

    logic seq_wr, diag_wr, diag_rd;
    logic unlocked, accept_wr, fire;
    logic [DATA_W-1:0] diag_val;

    diag_addr_dec #(
        .ADDR_W(ADDR_W), .SEQ_OFS(SEQ_OFS), .DIAG_OFS(DIAG_OFS)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
        .seq_wr(seq_wr), .diag_wr(diag_wr), .diag_rd(diag_rd)
    );

    diag_key_fsm #(
        .DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2), .KEY3(KEY3)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .seq_wr(seq_wr), .diag_wr(diag_wr),
        .wr_data(wr_data), .unlocked(unlocked), .accept_wr(accept_wr), .fire(fire)
    );

    diag_ctl_bits #(.DATA_W(DATA_W)) u_bits (
        .clk(clk), .rst_n(rst_n), .accept_wr(accept_wr),
        .d_mem_en(wr_data[B_MEM_EN]), .d_cpu_off(wr_data[B_CPU_OFF]),
        .d_reset(wr_data[B_RESET]), .d_rw_en(wr_data[B_RW_EN]),
        .d_no_boot(wr_data[B_NO_BOOT]), .d_clr_sig(wr_data[B_CLR_SIG]),
        .sig_fault_set(sig_fault_set), .unlocked(unlocked), .diag_val(diag_val)
    );

    always_comb begin
        rd_data     = diag_rd ? diag_val : '0;
        adapter_rst = fire;
    end

endmodule

// File: rtl/diag_unlock_chk.sv
`timescale 1ns/1ps
module diag_unlock_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SEQ_OFS  = 8'h04,
    parameter logic [ADDR_W-1:0] DIAG_OFS = 8'h08,
    parameter logic [DATA_W-1:0] KEY3     = 32'h0D
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              sig_fault_set,
    input logic              adapter_rst,
    input logic              unlocked,
    input logic [3:0]        cfg_bits,
    input logic              hist,
    input logic              sig_bad
);

    a_r2_open_after_last_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && wr_addr == SEQ_OFS && wr_data == KEY3));

    a_r4_locked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(cfg_bits));

    a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        adapter_rst |=> !adapter_rst);

    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        adapter_rst |-> $past(unlocked && wr_en && wr_addr == DIAG_OFS && wr_data[2]));

    a_r7_relocked: assert property (@(posedge clk) disable iff (!rst_n)
        adapter_rst |-> !unlocked);

    a_r7_history_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hist) |-> adapter_rst);

    a_r9_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
        sig_fault_set |=> sig_bad);

endmodule

bind diag_unlock_seq diag_unlock_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_OFS(SEQ_OFS),
    .DIAG_OFS(DIAG_OFS), .KEY3(KEY3)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sig_fault_set(sig_fault_set),
    .adapter_rst(adapter_rst), .unlocked(unlocked),
    .cfg_bits({diag_val[9], diag_val[4], diag_val[1], diag_val[0]}),
    .hist(diag_val[5]), .sig_bad(diag_val[6])
);

// File: tb/sim_diag_unlock_seq.sv
`timescale 1ns/1ps
module sim_diag_unlock_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sig_fault_set = 1'b0;
    logic        adapter_rst;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    diag_unlock_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .sig_fault_set(sig_fault_set), .adapter_rst(adapter_rst)
    );

    // behavioural reference model
    int  key_val [4] = '{4, 2, 7, 13};
    int  m_prog;            // keys matched, 4 means open
    bit  m_fire;
    bit  m_mem, m_cpu, m_rw, m_boot, m_hist, m_bad;

    always @(posedge clk) begin
        bit nfire;
        nfire = 0;
        if (!rst_n) begin
            m_prog = 0; m_fire = 0;
            m_mem = 0; m_cpu = 0; m_rw = 0; m_boot = 0; m_hist = 0; m_bad = 0;
        end else begin
            if (wr_en && wr_addr == 8'h04) begin
                if (m_prog < 4 && wr_data == 32'(key_val[m_prog])) m_prog = m_prog + 1;
                else m_prog = (wr_data == 32'h4) ? 1 : 0;
            end else if (wr_en && wr_addr == 8'h08) begin
                if (m_prog == 4) begin
                    m_mem = wr_data[0]; m_cpu = wr_data[1];
                    m_rw = wr_data[4];  m_boot = wr_data[9];
                    if (wr_data[10]) m_bad = 0;
                    if (wr_data[2]) begin m_hist = 1; nfire = 1; m_prog = 0; end
                end else m_prog = 0;
            end
            if (sig_fault_set) m_bad = 1;
            m_fire = nfire;
        end
    end

    function automatic logic [31:0] model_val();
        logic [31:0] v;
        v = '0;
        v[0] = m_mem; v[1] = m_cpu; v[4] = m_rw; v[5] = m_hist;
        v[6] = m_bad; v[7] = (m_prog == 4); v[9] = m_boot;
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // one clock with a single write, then compare against the model
    task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d, input bit sf);
        wr_en = we; wr_addr = a; wr_data = d; sig_fault_set = sf;
        @(posedge clk);
        #2;
        wr_en = 1'b0; sig_fault_set = 1'b0;
        rd_en = 1'b1; rd_addr = 8'h08;
        #1;
        check("R11 readback vs model", rd_data, model_val());
        check("R7 reset pulse vs model", {31'b0, adapter_rst}, {31'b0, m_fire});
    endtask

    task automatic seqw(input logic [31:0] d);
        cyc(1'b1, 8'h04, d, 1'b0);
    endtask

    task automatic diagw(input logic [31:0] d);
        cyc(1'b1, 8'h08, d, 1'b0);
    endtask

    task automatic unlock();
        seqw(32'h04); seqw(32'h02); seqw(32'h07); seqw(32'h0D);
    endtask

    task automatic rd_chk(input string tag, input bit en, input logic [7:0] a, input logic [31:0] exp);
        rd_en = en; rd_addr = a;
        #1;
        check(tag, rd_data, exp);
        rd_en = 1'b1; rd_addr = 8'h08;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rd_en = 1'b1; rd_addr = 8'h08;
        #1;
        // R1 reset state
        check("R1 reset readback", rd_data, 32'h0);
        check("R1 reset pulse low", {31'b0, adapter_rst}, 32'h0);
        rst_n = 1'b1;
        cyc(1'b0, 8'h00, 32'h0, 1'b0);

        // R11 read decode
        rd_chk("R11 other offset reads zero", 1'b1, 8'h04, 32'h0);
        rd_chk("R11 no strobe reads zero", 1'b0, 8'h08, 32'h0);

        // R4 locked write ignored
        diagw(32'h213);
        rd_chk("R4 locked write ignored", 1'b1, 8'h08, 32'h0);

        // R2 + R5: unlock with unrelated traffic between keys
        seqw(32'h04); seqw(32'h02);
        cyc(1'b1, 8'h0C, 32'h0D, 1'b0);
        rd_chk("R5 read between keys", 1'b1, 8'h08, 32'h0);
        seqw(32'h07); seqw(32'h0D);
        rd_chk("R2 R5 unlocked bit7", 1'b1, 8'h08, 32'h80);

        // R6 load control bits
        diagw(32'h213);
        rd_chk("R6 bits loaded and still open", 1'b1, 8'h08, 32'h293);

        // R8 and R9 signature fault handling
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        rd_chk("R9 fault sets bit6", 1'b1, 8'h08, 32'h2D3);
        diagw(32'h400);
        rd_chk("R8 clear bit6, bits 2/10 read 0", 1'b1, 8'h08, 32'h080);
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        cyc(1'b1, 8'h08, 32'h400, 1'b1);
        rd_chk("R9 set wins over clear", 1'b1, 8'h08, 32'h0C0);

        // R7 reset pulse
        wr_en = 1'b1; wr_addr = 8'h08; wr_data = 32'h004;
        @(posedge clk); #2;
        wr_en = 1'b0;
        #1;
        check("R7 pulse high after write", {31'b0, adapter_rst}, 32'h1);
        rd_chk("R7 history set and relocked", 1'b1, 8'h08, 32'h060);
        cyc(1'b0, 8'h00, 32'h0, 1'b0);
        check("R7 pulse lasts one cycle", {31'b0, adapter_rst}, 32'h0);
        diagw(32'h004);
        check("R7 no second pulse without key", {31'b0, adapter_rst}, 32'h0);

        // R3 restart on stray first key
        seqw(32'h04); seqw(32'h02); seqw(32'h04); seqw(32'h02); seqw(32'h07); seqw(32'h0D);
        rd_chk("R3 stray 0x04 restarts match", 1'b1, 8'h08, 32'h0E0);
        // R10 relock with sequence write
        seqw(32'h04);
        rd_chk("R10 sequence write relocks", 1'b1, 8'h08, 32'h060);
        seqw(32'h02); seqw(32'h07); seqw(32'h0D);
        rd_chk("R10 0x04 began new match", 1'b1, 8'h08, 32'h0E0);
        seqw(32'h00);
        seqw(32'h04); seqw(32'h02); seqw(32'h05); seqw(32'h07); seqw(32'h0D);
        rd_chk("R3 wrong key relocks", 1'b1, 8'h08, 32'h060);
        seqw(32'h04); seqw(32'h04); seqw(32'h02); seqw(32'h07); seqw(32'h0D);
        rd_chk("R3 repeated first key", 1'b1, 8'h08, 32'h0E0);
        seqw(32'h00);
        // R4 diag write abandons partial match
        seqw(32'h04); seqw(32'h02); diagw(32'h001); seqw(32'h07); seqw(32'h0D);
        rd_chk("R4 partial match abandoned", 1'b1, 8'h08, 32'h060);

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [7:0]  a;
            logic [31:0] d;
            r = $urandom_range(0, 9);
            a = (r < 5) ? 8'h04 : (r < 8) ? 8'h08 : 8'h10;
            if (a == 8'h04) d = 32'(key_val[$urandom_range(0, 3)]);
            else            d = $urandom & 32'h7FF;
            if (a == 8'h08 && $urandom_range(0, 3) != 0) d[2] = 1'b0;
            cyc($urandom_range(0, 4) != 0, a, d, $urandom_range(0, 15) == 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule